// File: doc/BRIEF.md
# Sixteen-bit I/O sequencing processor

This block is a very small processor that drives an 8-bit I/O bus. It runs a fixed program from an instruction ROM inside the block. The ROM contents are given as a packed parameter. Each 16-bit instruction is built the same way: the opcode sits in the top nibble, a register selector follows it, and the low byte carries an immediate value or an I/O port number. Typical use is glue firmware, for example a loop that polls a status port, masks a bit, and moves a byte from one port to another.

Each instruction takes two clock cycles. In the first cycle the word at the program counter is latched into an instruction register. In the second cycle the instruction executes. Any I/O strobe is asserted only in this second cycle, and it comes from registered state alone. A one-bit zero flag records whether the last value written to a register was zero, and a relative branch tests it. Subroutine calls use a small hardware return stack.

Top module: `ioseq_core`

## Requirements
- R1: After reset the program counter is 0, the return stack is empty, the zero flag is clear, and both strobes are low. The first instruction fetched after reset release is the word at address 0.
- R2: Instruction fields are: bits 15:12 opcode, bits 11:8 register select, bits 7:0 immediate or port number. Opcode 0x2 loads the immediate into the selected register.
- R3: Opcode 0x6 pulses `io_rd` for one cycle with `io_addr` equal to bits 7:0. The value on `io_rdata` in that cycle is stored in the selected register.
- R4: Opcode 0x7 pulses `io_wr` for one cycle with `io_addr` equal to bits 7:0 and `io_wdata` equal to the selected register.
- R5: Opcode 0x8 replaces the selected register with its AND with the immediate. Opcode 0x9 replaces it with its OR with the immediate.
- R6: Opcode 0xA calls the 12-bit absolute address in bits 11:0 and pushes the address of the following instruction. Opcode 0xB resumes at the most recent pushed address. Calls nest to a depth of at least 4.
- R7: Opcodes 0x2, 0x6, 0x8 and 0x9 set the zero flag to (result == 0); no other opcode changes it. Opcode 0xC moves to (its own address + bits 11:0) modulo 4096 when the flag is set, and to the next address otherwise. Offset 0xFFF therefore steps back one word.
- R8: Opcode 0xE continues at the 12-bit absolute address in bits 11:0.
- R9: Opcodes 0x0, 0x1, 0x3, 0x4, 0x5, 0xD and 0xF only advance the program counter, and each still takes two cycles.
- R10: Every instruction takes exactly two cycles. `io_rd` and `io_wr` are never high together, and neither is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | output | 8 | Port number during a strobe, 0 otherwise |
| io_wdata | output | 8 | Write data during `io_wr`, 0 otherwise |
| io_wr | output | 1 | One-cycle write strobe |
| io_rd | output | 1 | One-cycle read strobe |
| io_rdata | input | 8 | Read data, sampled at the clock edge that ends the `io_rd` cycle |

## Verification
Instruction number k after reset release (counting from 0) executes in the cycle that follows clock edge 2k+1. Any strobe it makes is therefore due in that cycle, and a register it writes is visible to instruction k+1. The bench counts clock edges from reset release. At each falling edge it records every strobe together with its cycle number, and it compares the record against a table of expected (cycle, kind, port, data) entries. This table was derived by hand from the test program. A branch taken wrongly, a missing call level, or a no-op that costs extra cycles shifts the cycle stamps of later entries, or it adds an entry for a trap word.

// File: rtl/ioseq_pkg.sv
package ioseq_pkg;

    localparam int INSTR_W = 16;
    localparam int PC_W    = 12;
    localparam int DATA_W  = 8;

    typedef enum logic [3:0] {
        OP_LDI  = 4'h2,
        OP_IN   = 4'h6,
        OP_OUT  = 4'h7,
        OP_ANDI = 4'h8,
        OP_ORI  = 4'h9,
        OP_CALL = 4'hA,
        OP_RET  = 4'hB,
        OP_BZ   = 4'hC,
        OP_JUMP = 4'hE
    } opcode_e;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [PC_W-1:0]     pc;
        logic [INSTR_W-1:0]  ir;
        logic                zf;
    } core_state_s;

endpackage

// File: rtl/ioseq_rom.sv
module ioseq_rom #(
    parameter int                           ADDR_W  = 6,
    parameter logic [(16 << ADDR_W)-1:0]    CONTENT = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [15:0]       word_o
);
    localparam int WORDS = 1 << ADDR_W;

    logic [15:0] words [WORDS];

    for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
        assign words[gi] = CONTENT[gi*16 +: 16];
    end

    assign word_o = words[addr_i];

endmodule

// File: rtl/ioseq_regfile.sv
module ioseq_regfile #(
    parameter int NREGS  = 16,
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [SEL_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [SEL_W-1:0]  raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] regs_q [NREGS];
    logic [DATA_W-1:0] regs_d [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we_i) begin
            regs_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    assign rdata_o = regs_q[raddr_i];

    // R2: a register write is held by the register in the next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (regs_q[$past(waddr_i)] == $past(wdata_i)));

endmodule

// File: rtl/ioseq_retstack.sv
module ioseq_retstack #(
    parameter int DEPTH = 4,
    parameter int W     = 12,
    localparam int SP_W  = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] push_data_i,
    output logic [W-1:0] top_o
);
    logic [W-1:0]    mem_q [DEPTH];
    logic [W-1:0]    mem_d [DEPTH];
    logic [SP_W-1:0] sp_q, sp_d;
    logic            full, empty;

    assign full  = (sp_q == SP_W'(DEPTH));
    assign empty = (sp_q == '0);

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        sp_d = sp_q;
        if (push_i && !full) begin
            mem_d[IDX_W'(sp_q)] = push_data_i;
            sp_d = sp_q + 1'b1;
        end else if (pop_i && !empty) begin
            sp_d = sp_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            sp_q <= sp_d;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign top_o = empty ? '0 : mem_q[IDX_W'(sp_q - 1'b1)];

    // R6: a call deepens the stack by one, a return shortens it by one
    a_r6_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full) |=> (sp_q == $past(sp_q) + 1'b1));
    a_r6_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty) |=> (sp_q == $past(sp_q) - 1'b1));
    a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        sp_q <= SP_W'(DEPTH));

endmodule

// File: rtl/ioseq_core.sv
module ioseq_core
    import ioseq_pkg::*;
#(
    parameter int                        ROM_AW      = 6,
    parameter int                        NREGS       = 16,
    parameter int                        STACK_DEPTH = 4,
    parameter logic [(16 << ROM_AW)-1:0] PROGRAM     = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [7:0] io_addr,
    output logic [7:0] io_wdata,
    output logic       io_wr,
    output logic       io_rd,
    input  logic [7:0] io_rdata
);
    localparam int SEL_W = $clog2(NREGS);

    core_state_s        s_q, s_d;
    logic [INSTR_W-1:0] rom_word;
    logic [DATA_W-1:0]  imm;
    logic [SEL_W-1:0]   rsel;
    logic [DATA_W-1:0]  rf_rdata;
    logic [DATA_W-1:0]  rf_wdata;
    logic               rf_we;
    logic               stk_push, stk_pop;
    logic [PC_W-1:0]    stk_top;
    logic [PC_W-1:0]    pc_next_seq;
    logic               rd_d, wr_d;

    assign imm         = s_q.ir[7:0];
    assign rsel        = s_q.ir[8 +: SEL_W];
    assign pc_next_seq = s_q.pc + 1'b1;

    ioseq_rom #(
        .ADDR_W  (ROM_AW),
        .CONTENT (PROGRAM)
    ) i_rom (
        .addr_i (s_q.pc[ROM_AW-1:0]),
        .word_o (rom_word)
    );

    ioseq_regfile #(
        .NREGS  (NREGS),
        .DATA_W (DATA_W)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (rf_we),
        .waddr_i (rsel),
        .wdata_i (rf_wdata),
        .raddr_i (rsel),
        .rdata_o (rf_rdata)
    );

    ioseq_retstack #(
        .DEPTH (STACK_DEPTH),
        .W     (PC_W)
    ) i_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (stk_push),
        .pop_i       (stk_pop),
        .push_data_i (pc_next_seq),
        .top_o       (stk_top)
    );

    // Next-state logic: fetch latches the word, execute acts on it
    always_comb begin
        s_d      = s_q;
        rf_we    = 1'b0;
        rf_wdata = '0;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        rd_d     = 1'b0;
        wr_d     = 1'b0;
        if (s_q.phase == PH_FETCH) begin
            s_d.ir    = rom_word;
            s_d.phase = PH_EXEC;
        end else begin
            s_d.phase = PH_FETCH;
            s_d.pc    = pc_next_seq;
            case (s_q.ir[15:12])
                OP_LDI: begin
                    rf_we    = 1'b1;
                    rf_wdata = imm;
                end
                OP_IN: begin
                    rd_d     = 1'b1;
                    rf_we    = 1'b1;
                    rf_wdata = io_rdata;
                end
                OP_OUT: begin
                    wr_d = 1'b1;
                end
                OP_ANDI: begin
                    rf_we    = 1'b1;
                    rf_wdata = rf_rdata & imm;
                end
                OP_ORI: begin
                    rf_we    = 1'b1;
                    rf_wdata = rf_rdata | imm;
                end
                OP_CALL: begin
                    stk_push = 1'b1;
                    s_d.pc   = s_q.ir[PC_W-1:0];
                end
                OP_RET: begin
                    stk_pop = 1'b1;
                    s_d.pc  = stk_top;
                end
                OP_BZ: begin
                    if (s_q.zf) begin
                        s_d.pc = s_q.pc + s_q.ir[PC_W-1:0];
                    end
                end
                OP_JUMP: begin
                    s_d.pc = s_q.ir[PC_W-1:0];
                end
                default: begin
                end
            endcase
            if (rf_we) begin
                s_d.zf = (rf_wdata == '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_FETCH, pc: '0, ir: '0, zf: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign io_rd    = rd_d;
    assign io_wr    = wr_d;
    assign io_addr  = (rd_d || wr_d) ? imm : '0;
    assign io_wdata = wr_d ? rf_rdata : '0;

    // R10: the two phases alternate, so every instruction takes two cycles
    a_r10_fetch_then_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_FETCH) |=> (s_q.phase == PH_EXEC));
    a_r10_exec_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_EXEC) |=> (s_q.phase == PH_FETCH));
    a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_wr));
    // R3 / R4: strobes last a single cycle
    a_r3_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd |=> !io_rd);
    a_r4_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |=> !io_wr);
    // R7: the flag only moves on an executed register-writing opcode
    a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_we |=> $stable(s_q.zf));

endmodule

// File: tb/test_ioseq_core.sv
module test_ioseq_core;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 7;
    localparam int WORDS      = 1 << AW;
    localparam int LOG_MAX    = 32;

    function automatic logic [WORDS*16-1:0] build_prog();
        logic [WORDS*16-1:0] p;
        p = {WORDS{16'h7F3F}};          // trap word: any stray execution writes port 0x3F
        p['h000*16 +: 16] = 16'h2103;
        p['h001*16 +: 16] = 16'h7120;
        p['h002*16 +: 16] = 16'h2F80;
        p['h003*16 +: 16] = 16'h9F01;
        p['h004*16 +: 16] = 16'h7F21;
        p['h005*16 +: 16] = 16'h8F0F;
        p['h006*16 +: 16] = 16'h7F22;
        p['h007*16 +: 16] = 16'h6233;
        p['h008*16 +: 16] = 16'h7223;
        p['h009*16 +: 16] = 16'hA020;
        p['h00A*16 +: 16] = 16'h7126;
        p['h00B*16 +: 16] = 16'h3000;
        p['h00C*16 +: 16] = 16'h8300;
        p['h00D*16 +: 16] = 16'hC004;
        p['h011*16 +: 16] = 16'h8101;
        p['h012*16 +: 16] = 16'hC004;
        p['h013*16 +: 16] = 16'h7127;
        p['h014*16 +: 16] = 16'h6410;
        p['h015*16 +: 16] = 16'hC002;
        p['h017*16 +: 16] = 16'h7428;
        p['h018*16 +: 16] = 16'hE040;
        p['h020*16 +: 16] = 16'h7124;
        p['h021*16 +: 16] = 16'hA030;
        p['h022*16 +: 16] = 16'hB000;
        p['h030*16 +: 16] = 16'h7F25;
        p['h031*16 +: 16] = 16'hB000;
        p['h040*16 +: 16] = 16'h2500;
        p['h041*16 +: 16] = 16'hE043;
        p['h042*16 +: 16] = 16'h9501;
        p['h043*16 +: 16] = 16'hCFFF;
        p['h044*16 +: 16] = 16'h752A;
        p['h045*16 +: 16] = 16'hE045;
        return p;
    endfunction

    typedef struct packed {
        logic       is_rd;
        logic [7:0] cyc;
        logic [7:0] addr;
        logic [7:0] data;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'd3,  8'h20, 8'h03, 4'd2},  // R2 load then R4 write, first word at 0 (R1)
        '{1'b0, 8'd9,  8'h21, 8'h81, 4'd5},  // R5 OR immediate
        '{1'b0, 8'd13, 8'h22, 8'h01, 4'd5},  // R5 AND immediate
        '{1'b1, 8'd15, 8'h33, 8'h00, 4'd3},  // R3 read strobe, port 0x33
        '{1'b0, 8'd17, 8'h23, 8'h96, 4'd3},  // R3 read data landed in the register
        '{1'b0, 8'd21, 8'h24, 8'h03, 4'd6},  // R6 inside first call
        '{1'b0, 8'd25, 8'h25, 8'h01, 4'd6},  // R6 nested call
        '{1'b0, 8'd31, 8'h26, 8'h03, 4'd6},  // R6 both returns done
        '{1'b0, 8'd43, 8'h27, 8'h01, 4'd9},  // R9 no-op cost, R7 taken then untaken branch
        '{1'b1, 8'd45, 8'h10, 8'h00, 4'd3},  // R3 read of zero
        '{1'b0, 8'd49, 8'h28, 8'h00, 4'd7},  // R7 flag from read, branch taken
        '{1'b0, 8'd63, 8'h2A, 8'h01, 4'd8}   // R8 jump, R7 backward branch, flag kept over jump
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr, io_wdata, io_rdata;
    logic       io_wr, io_rd;

    int         n_vec = 0;
    int         n_bad = 0;
    int         cyc;
    int         n_ev;
    int         ev_cyc  [LOG_MAX];
    logic       ev_rd   [LOG_MAX];
    logic [7:0] ev_addr [LOG_MAX];
    logic [7:0] ev_data [LOG_MAX];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign io_rdata = (io_addr == 8'h10) ? 8'h00 : (io_addr ^ 8'hA5);

    ioseq_core #(
        .ROM_AW      (AW),
        .NREGS       (16),
        .STACK_DEPTH (4),
        .PROGRAM     (build_prog())
    ) i_ioseq_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_rdata (io_rdata)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            n_ev <= 0;
        end else if (io_wr || io_rd) begin
            if (n_ev < LOG_MAX) begin
                ev_cyc[n_ev]  <= cyc;
                ev_rd[n_ev]   <= io_rd;
                ev_addr[n_ev] <= io_addr;
                ev_data[n_ev] <= io_wr ? io_wdata : 8'h00;
            end
            n_ev <= n_ev + 1;
        end
    end

    task automatic check_vec(input int idx, input vec_t v);
        n_vec++;
        if (idx >= n_ev || ev_rd[idx] !== v.is_rd || ev_cyc[idx] != int'(v.cyc) ||
            ev_addr[idx] !== v.addr || ev_data[idx] !== v.data) begin
            n_bad++;
            if (idx >= n_ev)
                $display("FAIL R%0d event %0d: got none (%0d logged), expected rd=%0b cyc=%0d addr=%h data=%h",
                         v.req, idx, n_ev, v.is_rd, v.cyc, v.addr, v.data);
            else
                $display("FAIL R%0d event %0d: got rd=%0b cyc=%0d addr=%h data=%h, expected rd=%0b cyc=%0d addr=%h data=%h",
                         v.req, idx, ev_rd[idx], ev_cyc[idx], ev_addr[idx], ev_data[idx],
                         v.is_rd, v.cyc, v.addr, v.data);
        end
    endtask

    task automatic check_eq(input string req, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d, expected %0d", req, got, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: strobes and bus quiet while reset is held
        check_eq("R1 io_wr in reset", int'(io_wr), 0);
        check_eq("R1 io_rd in reset", int'(io_rd), 0);
        check_eq("R1 io_addr in reset", int'(io_addr), 0);
        rst_n = 1'b1;
        repeat (90) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < NVEC; i++) begin
            check_vec(i, VECS[i]);
        end
        // R7 / R9: no trap word was ever executed, so no extra strobes
        check_eq("R7 total strobe count", n_ev, NVEC);

        // R1: reset in mid-run restarts at address 0
        rst_n = 1'b0;
        #1;
        check_eq("R1 io_wr after async reset", int'(io_wr), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check_eq("R1 strobes after restart", n_ev, 1);
        check_vec(0, VECS[0]);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: run did not end, got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule